// File: doc/BRIEF.md
# Daisy-Chain TDM Output Serializer

This block is the serial output stage of one node in a chain of up to four stereo nodes sharing a time-division multiplexed bus. The bus runs in slave timing. An external frame clock marks each frame, and an external bit clock runs at 256 periods per frame. A frame holds eight 32-bit slots. Each slot carries a 24-bit two's-complement word, most significant bit first. The block runs from a faster system clock. It detects the edges of the bit clock by sampling it on that system clock.

The node writes its own left and right words into the first two slots of every frame. The serial stream arriving from the previous node is sampled on the bit clock's rising edges and retransmitted 64 bit clocks later, which is two slots. Because of this delay, each node places its own pair ahead of the pairs that came before it, and a chain of four nodes fills all eight slots. Two word alignments are supported. In MSB-justified alignment the MSB sits in the first bit of the slot. In I2S-style alignment the MSB is moved one bit clock later.

Top module: `tdm_chain_tx`

## Requirements
- R1: After reset, `tdm_out_o` is 0. It stays 0 until the first frame start.
- R2: A frame start is a bit-clock rising edge at which `fclk_i` is sampled 1, having been sampled 0 at the previous rising edge. That bit period is position 0. Later rising edges advance the position by one. After 256 positions the count wraps to 0. Slot n covers positions 32n to 32n+31.
- R3: `tdm_out_o` changes only in the system-clock cycle that follows a detected bit-clock falling edge. The value driven after the falling edge that closes position p is the bit for position p.
- R4: With `i2s_i` = 0, slot 0 carries the left word and slot 1 carries the right word. Bit k of the slot (k = 0..23) is word bit 23-k.
- R5: In slots 0 and 1, every bit that carries no data bit is driven 0. With `i2s_i` = 0 these are slot bits 24..31. With `i2s_i` = 1 they are slot bit 0 and slot bits 25..31.
- R6: With `i2s_i` = 1, slot bit k (k = 1..24) carries word bit 24-k.
- R7: At positions 64..255, the output is the `tdm_in_i` value that was sampled at the rising edge 64 bit clocks earlier. An upstream pair therefore reappears two slots later, behind this node's own pair.
- R8: `left_i` and `right_i` are captured at the frame start. Changing them during a frame has no effect on the output until the next frame.
- R9: A frame start that arrives before 256 positions have elapsed restarts the count at position 0. The frame that begins there is laid out exactly as a normal frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bus bit clock, 256 periods per frame |
| fclk_i | input | 1 | Bus frame clock; a rising edge marks position 0 |
| tdm_in_i | input | 1 | Serial stream from the previous node |
| left_i | input | DATA_W | This node's left word |
| right_i | input | DATA_W | This node's right word |
| i2s_i | input | 1 | 0: MSB-justified, 1: MSB one bit clock later |
| tdm_out_o | output | 1 | Serial stream to the next node |

## Verification
The assertions check the following on every cycle:
- the output stays silent until framing;
- the output moves only right after a falling bit-clock edge;
- the position is zeroed at each frame start and otherwise steps modulo 256;
- the padding bits of the two own slots stay low.

The bench's scenarios show the rest:
- the word contents in both alignments;
- the two-slot forwarding of upstream data, including a node-1-style upstream frame that reappears in slots 2 and 3;
- that word changes in the middle of a frame are ignored;
- that a shortened frame restarts correctly.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  localparam int unsigned DEF_DATA_W = 24;
  localparam int unsigned DEF_SLOT_W = 32;
  localparam int unsigned DEF_SLOTS  = 8;

  typedef enum logic {
    ALIGN_MSB = 1'b0,
    ALIGN_I2S = 1'b1
  } align_e;
endpackage

// File: rtl/tdm_clk_edges.sv
// Detects bus clock edges in the system clock domain and flags the frame start.
module tdm_clk_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fclk,
  output logic rise_evt,
  output logic fall_evt,
  output logic frame_start
);
  logic bclk_q;
  logic fclk_q;

  assign rise_evt    = bclk & ~bclk_q;
  assign fall_evt    = ~bclk & bclk_q;
  assign frame_start = rise_evt & fclk & ~fclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (rise_evt) fclk_q <= fclk;
    end
  end
endmodule

// File: rtl/tdm_frame_ctr.sv
// Bit position within the frame, advanced on bus clock rising edges.
module tdm_frame_ctr #(
  parameter int unsigned FRAME = 256,
  localparam int unsigned POS_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic             frame_start,
  output logic [POS_W-1:0] pos,
  output logic             framed,
  output logic [POS_W-1:0] pos_nxt,
  output logic             framed_nxt
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME - 1);

  always_comb begin
    framed_nxt = framed | frame_start;
    if (frame_start)      pos_nxt = '0;
    else if (!framed)     pos_nxt = pos;
    else if (pos == LAST) pos_nxt = '0;
    else                  pos_nxt = pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      framed <= 1'b0;
    end else if (rise_evt) begin
      pos    <= pos_nxt;
      framed <= framed_nxt;
    end
  end
endmodule

// File: rtl/tdm_delay_line.sv
// Shift delay for the upstream stream; tap holds the bit from DEPTH rising edges back
// until the next shift.
module tdm_delay_line #(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic din,
  output logic tap
);
  logic [DEPTH-1:0] line;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)        line[i] <= 1'b0;
      else if (rise_evt) line[i] <= (i == 0) ? din : line[(i == 0) ? 0 : i-1];
    end
  end

  assign tap = line[DEPTH-1];
endmodule

// File: rtl/tdm_slot_mux.sv
// Chooses own word bits or forwarded bits; a pending bit is formed on the rising
// edge and driven out on the falling edge.
module tdm_slot_mux
  import tdm_chain_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  parameter int unsigned FRAME  = DEF_SLOT_W * DEF_SLOTS,
  localparam int unsigned POS_W = $clog2(FRAME),
  localparam int unsigned OWN_W = 2 * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              frame_start,
  input  logic              framed_nxt,
  input  logic [POS_W-1:0]  pos_nxt,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  align_e            align,
  input  logic              fwd_bit,
  output logic              tdm_out
);
  logic [DATA_W-1:0] own_l, own_r;
  logic [DATA_W-1:0] cur_l, cur_r;
  logic              pend, pend_d;

  // Bit of the own pair at a frame position, for a given alignment.
  function automatic logic own_bit(input int unsigned p,
                                   input logic [DATA_W-1:0] l,
                                   input logic [DATA_W-1:0] r,
                                   input align_e al);
    int unsigned b, lead;
    logic [DATA_W-1:0] w;
    b    = p % SLOT_W;
    lead = (al == ALIGN_I2S) ? 1 : 0;
    w    = (p < SLOT_W) ? l : r;
    if (b >= lead && b < lead + DATA_W) return w[DATA_W-1-(b-lead)];
    return 1'b0;
  endfunction

  assign cur_l = frame_start ? left_i  : own_l;
  assign cur_r = frame_start ? right_i : own_r;

  always_comb begin
    if (!framed_nxt)                 pend_d = 1'b0;
    else if (int'(pos_nxt) >= OWN_W) pend_d = fwd_bit;
    else                             pend_d = own_bit(int'(pos_nxt), cur_l, cur_r, align);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_l   <= '0;
      own_r   <= '0;
      pend    <= 1'b0;
      tdm_out <= 1'b0;
    end else begin
      if (frame_start) begin
        own_l <= left_i;
        own_r <= right_i;
      end
      if (rise_evt) pend    <= pend_d;
      if (fall_evt) tdm_out <= pend;
    end
  end
endmodule

// File: rtl/tdm_chain_tx.sv
module tdm_chain_tx
  import tdm_chain_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  parameter int unsigned SLOTS  = DEF_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fclk_i,
  input  logic              tdm_in_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              i2s_i,
  output logic              tdm_out_o
);
  localparam int unsigned FRAME = SLOT_W * SLOTS;
  localparam int unsigned DELAY = 2 * SLOT_W;
  localparam int unsigned POS_W = $clog2(FRAME);

  logic             rise_evt, fall_evt, frame_start;
  logic [POS_W-1:0] pos, pos_nxt;
  logic             framed, framed_nxt;
  logic             fwd_bit;
  align_e           align;

  assign align = i2s_i ? ALIGN_I2S : ALIGN_MSB;

  tdm_clk_edges u_edges (
    .clk(clk), .rst_n(rst_n), .bclk(bclk_i), .fclk(fclk_i),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_start(frame_start)
  );

  tdm_frame_ctr #(.FRAME(FRAME)) u_ctr (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .frame_start(frame_start),
    .pos(pos), .framed(framed), .pos_nxt(pos_nxt), .framed_nxt(framed_nxt)
  );

  tdm_delay_line #(.DEPTH(DELAY)) u_dly (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .din(tdm_in_i), .tap(fwd_bit)
  );

  tdm_slot_mux #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .FRAME(FRAME)) u_mux (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .frame_start(frame_start), .framed_nxt(framed_nxt), .pos_nxt(pos_nxt),
    .left_i(left_i), .right_i(right_i), .align(align), .fwd_bit(fwd_bit),
    .tdm_out(tdm_out_o)
  );
endmodule

// File: rtl/tdm_chain_tx_chk.sv
module tdm_chain_tx_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned FRAME  = 256,
  localparam int unsigned POS_W = $clog2(FRAME)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             frame_start,
  input logic             framed,
  input logic [POS_W-1:0] pos,
  input logic             i2s,
  input logic             tdm_out
);
  int unsigned b;
  logic        pad_pos;

  always_comb begin
    b       = int'(pos) % SLOT_W;
    pad_pos = i2s ? (b == 0 || b > DATA_W) : (b >= DATA_W);
  end

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdm_out) |-> $past(fall_evt)); // R3

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |-> !tdm_out); // R1

  AST_START_POS0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pos == '0)); // R2

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && framed && !frame_start) |=>
      (int'(pos) == (int'($past(pos)) + 1) % FRAME)); // R2

  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && framed && int'(pos) < 2 * SLOT_W && pad_pos) |=> !tdm_out); // R5
endmodule

bind tdm_chain_tx tdm_chain_tx_chk #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .FRAME(FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .frame_start(frame_start), .framed(framed), .pos(pos), .i2s(i2s_i),
  .tdm_out(tdm_out_o)
);

// File: tb/tb_tdm_chain_tx.sv
`timescale 1ns/1ps
module tb_tdm_chain_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fclk = 1'b0, tdm_in = 1'b0, i2s = 1'b0;
  logic [23:0] left = '0, right = '0;
  logic        tdm_out;

  int    checks = 0, errors = 0;
  bit    done = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    hist[$];
  logic  last_out = 1'b0;

  bit          fprev_m = 0, framed_m = 0;
  int          pos_m = 0;
  logic [23:0] lm = '0, rm = '0;
  string       cur_tag = "";
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  tdm_chain_tx dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .tdm_in_i(tdm_in),
    .left_i(left), .right_i(right), .i2s_i(i2s), .tdm_out_o(tdm_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Expected own-slot bit, from the slot layout in R4 and R6.
  function automatic bit exp_own(int p, logic [23:0] l, logic [23:0] r, bit al);
    int slot = p / 32;
    int b    = p % 32;
    int first = al ? 1 : 0;
    logic [23:0] w = (slot == 0) ? l : r;
    if (b >= first && b < first + 24) return w[23 - (b - first)];
    return 1'b0;
  endfunction

  // Driver: one bit period; pushes the expected output for it.
  task automatic bit_step(input bit f, input bit d);
    bit    e;
    string t;
    int    b;
    if (f && !fprev_m) begin
      pos_m = 0; framed_m = 1; lm = left; rm = right;
    end else if (framed_m) pos_m = (pos_m + 1) % 256;
    fprev_m = f;
    b = pos_m % 32;
    if (!framed_m) begin
      e = 0; t = "R1";
    end else if (pos_m >= 64) begin
      e = (hist.size() >= 64) ? hist[hist.size() - 64] : 1'b0;
      t = "R7";
    end else begin
      e = exp_own(pos_m, lm, rm, i2s);
      if (pos_m == 0) t = "R2";
      else if (i2s ? (b == 0 || b > 24) : (b >= 24)) t = "R5";
      else t = i2s ? "R6" : "R4";
    end
    if (cur_tag != "" && framed_m) t = cur_tag;
    hist.push_back(d);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bclk = 1'b1; fclk = f; tdm_in = d;
    repeat (2) @(negedge clk);
    bclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic bit lfsr_bit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  // up_mode 0: random upstream; 1: node-1-style frame with words in slots 0 and 1.
  task automatic run_frame(input int nbits, input logic [23:0] l, input logic [23:0] r,
                           input int chg_at, input logic [23:0] l2, input logic [23:0] r2,
                           input int up_mode);
    logic [23:0] ul = 24'h123456, ur = 24'hFEDCBA;
    left = l; right = r;
    for (int i = 0; i < nbits; i++) begin
      bit d;
      if (i == chg_at) begin left = l2; right = r2; end
      if (up_mode == 0) d = lfsr_bit();
      else if (i < 24) d = ul[23 - i];
      else if (i >= 32 && i < 56) d = ur[23 - (i - 32)];
      else d = 1'b0;
      bit_step(i < nbits / 2, d);
    end
  endtask

  // Monitor: compares after each falling bit-clock edge.
  initial begin
    forever begin
      @(negedge bclk);
      #15;
      if (exp_q.size() > 0) begin
        chk(tdm_out, exp_q.pop_front(), tag_q.pop_front());
        last_out = tdm_out;
      end
    end
  end

  // R3: output holds while the bit clock is high.
  initial begin
    forever begin
      @(posedge bclk);
      #15;
      chk(tdm_out, last_out, "R3");
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tdm_out, 1'b0, "R1");
    for (int i = 0; i < 10; i++) bit_step(1'b0, lfsr_bit()); // R1: no frame yet
    i2s = 1'b0;
    run_frame(256, 24'h800001, 24'h7FFFFF, -1, '0, '0, 0);
    run_frame(256, 24'hA5A5A5, 24'h5A5A5A, -1, '0, '0, 0);
    run_frame(256, 24'hFFFFFF, 24'h000001, -1, '0, '0, 0);
    cur_tag = "R8";
    run_frame(256, 24'hC3C3C3, 24'h3C3C3C, 5, 24'h0F0F0F, 24'hF0F0F0, 0);
    cur_tag = "";
    run_frame(256, 24'h0F0F0F, 24'hF0F0F0, -1, '0, '0, 0);
    i2s = 1'b1;
    run_frame(256, 24'h800001, 24'hC00003, -1, '0, '0, 0);
    run_frame(256, 24'h7FFFFE, 24'h123456, -1, '0, '0, 0);
    i2s = 1'b0;
    run_frame(100, 24'h111111, 24'h222222, -1, '0, '0, 0);
    cur_tag = "R9";
    run_frame(256, 24'h9ABCDE, 24'h654321, -1, '0, '0, 0);
    cur_tag = "";
    run_frame(256, 24'hAAAAAA, 24'h555555, -1, '0, '0, 1);
    cur_tag = "R7";
    run_frame(256, 24'h010203, 24'h040506, -1, '0, '0, 0);
    cur_tag = "";
    for (int i = 0; i < 4; i++) bit_step(1'b0, 1'b0);
    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule